// File: doc/BRIEF.md
# Strided Vector Address Generator

This block expands a single vector memory operation into the stream of element addresses that a load/store unit consumes. A one-cycle start pulse presents four fields at once: a base address, an offset relative to that base, a per-element increment (stride) and an element count. The block captures them and then issues one element address per cycle under a valid/ready handshake. Each address comes with the element's index and a flag that marks the final element.

The increment is a free value. A value of 1 walks contiguous storage. Any other value walks non-contiguous storage, and a large value acts as a negative step because all address arithmetic wraps at the address width. The element count alone decides when the stream stops. A count of zero produces no addresses and only signals completion. The downstream consumer can stall the stream at any time by holding ready low. A start pulse that arrives while a stream is in progress is discarded.

Top module: `vagu_top`

## Requirements
- R1: After reset, `elem_valid`, `busy` and `done` are low.
- R2: The cycle after an accepted start with nonzero count, `elem_valid` is high, `elem_addr` equals base plus offset, and `elem_index` is 0.
- R3: After each handshake (`elem_valid` and `elem_ready` both high) on an element that is not the last, the next element is presented in the following cycle. Its address is the previous address plus the captured increment, and its index is the previous index plus 1.
- R4: The increment is arbitrary: an increment of 1 yields consecutive addresses, an increment of 0 repeats one address, and any other value is added unchanged.
- R5: A count of N (N ≥ 1) yields exactly N handshaken elements, indexed 0 to N-1. `elem_last` is high on index N-1 only.
- R6: While `elem_valid` is high and `elem_ready` is low, `elem_addr`, `elem_index` and `elem_last` hold their values, and `elem_valid` stays high.
- R7: The cycle after the handshake of the last element, `elem_valid` and `busy` are low and `done` is high for exactly one cycle.
- R8: A start with a count of 0 produces no element. In the next cycle `done` is high for one cycle, and `busy` stays low throughout.
- R9: Address arithmetic wraps modulo 2^ADDR_W, both for base plus offset and for each increment.
- R10: A start pulse while `busy` is high is ignored. The running stream keeps its addresses, indices and count.
- R11: `busy` is high from the cycle after an accepted nonzero start until the cycle after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a new stream |
| base_addr | input | ADDR_W | Base address, sampled with start |
| addr_offset | input | ADDR_W | Offset added to the base for element 0 |
| addr_step | input | ADDR_W | Increment between successive elements |
| elem_count | input | LEN_W | Number of elements in the stream |
| elem_ready | input | 1 | Consumer accepts the current element |
| elem_valid | output | 1 | An element address is presented |
| elem_addr | output | ADDR_W | Current element address |
| elem_index | output | LEN_W | Position of the current element |
| elem_last | output | 1 | Current element is the final one |
| busy | output | 1 | A stream is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the wrap of the address past the top of the space. A design that saturated or widened there would emit the wrong low addresses. A negative stride given as a large unsigned increment targets the same fault. Stalls with ready low probe whether the address or index creeps forward without a handshake, which would skip elements. Counts of 1 and 0 check for the classic off-by-one faults: a missing or extra element, a missing last flag, or a done pulse that is absent or lasts two cycles. A start injected mid-stream checks that a design does not reload its fields and corrupt the running sequence.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vagu_state_e;
endpackage

// File: rtl/vagu_seq_ctrl.sv
module vagu_seq_ctrl
  import vagu_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] count_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             step_o,
  output logic             valid_o,
  output logic             last_o,
  output logic [LEN_W-1:0] index_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  vagu_state_e      state_q;
  logic [LEN_W-1:0] idx_q, cnt_q;
  logic             last_q, done_q;
  logic             accept, zero_req, fire;
  logic [LEN_W-1:0] idx_nxt;

  // a new request is only taken while idle
  assign accept   = start_i && (state_q == ST_IDLE);
  assign zero_req = accept && (count_i == '0);
  assign load_o   = accept && (count_i != '0);
  assign fire     = (state_q == ST_RUN) && ready_i;
  assign step_o   = fire && !last_q;
  assign idx_nxt  = idx_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= zero_req || (fire && last_q);
      if (load_o) begin
        state_q <= ST_RUN;
        idx_q   <= '0;
        cnt_q   <= count_i;
        last_q  <= (count_i == ONE);
      end else if (step_o) begin
        idx_q  <= idx_nxt;
        last_q <= (idx_nxt == cnt_q - ONE);
      end else if (fire) begin
        state_q <= ST_IDLE;
        last_q  <= 1'b0;
      end
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign last_o  = last_q;
  assign index_o = idx_q;
  assign done_o  = done_q;
endmodule

// File: rtl/vagu_addr_acc.sv
module vagu_addr_acc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, stride_q;

  // sums are kept at ADDR_W bits, so carries out of the top are dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      addr_q   <= base_i + offset_i;
      stride_q <= stride_i;
    end else if (step_i) begin
      addr_q   <= addr_q + stride_q;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vagu_top.sv
module vagu_top #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] addr_offset,
  input  logic [ADDR_W-1:0] addr_step,
  input  logic [LEN_W-1:0]  elem_count,
  input  logic              elem_ready,
  output logic              elem_valid,
  output logic [ADDR_W-1:0] elem_addr,
  output logic [LEN_W-1:0]  elem_index,
  output logic              elem_last,
  output logic              busy,
  output logic              done
);
  logic load, step, valid;

  vagu_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .count_i (elem_count),
    .ready_i (elem_ready),
    .load_o  (load),
    .step_o  (step),
    .valid_o (valid),
    .last_o  (elem_last),
    .index_o (elem_index),
    .done_o  (done)
  );

  vagu_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .step_i   (step),
    .base_i   (base_addr),
    .offset_i (addr_offset),
    .stride_i (addr_step),
    .addr_o   (elem_addr)
  );

  assign elem_valid = valid;
  assign busy       = valid;
endmodule

// File: rtl/vagu_chk.sv
module vagu_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] addr_offset,
  input logic [LEN_W-1:0]  elem_count,
  input logic              elem_ready,
  input logic              elem_valid,
  input logic [ADDR_W-1:0] elem_addr,
  input logic [LEN_W-1:0]  elem_index,
  input logic              elem_last,
  input logic              busy,
  input logic              done
);
  AST_FIRST_ELEM: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && elem_count != '0) |=>
      (elem_valid && elem_index == '0 && elem_addr == $past(base_addr + addr_offset))); // R2

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && elem_ready && !elem_last) |=>
      (elem_valid && elem_index == $past(elem_index) + 1'b1)); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && !elem_ready) |=>
      (elem_valid && $stable(elem_addr) && $stable(elem_index) && $stable(elem_last))); // R6

  AST_END: assert property (@(posedge clk) disable iff (rst)
    (elem_valid && elem_ready && elem_last) |=> (!elem_valid && !busy && done)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && elem_count == '0) |=> (done && !elem_valid && !busy)); // R8

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(elem_ready && elem_last)) |=> (busy && elem_valid)); // R10
endmodule

bind vagu_top vagu_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .base_addr   (base_addr),
  .addr_offset (addr_offset),
  .elem_count  (elem_count),
  .elem_ready  (elem_ready),
  .elem_valid  (elem_valid),
  .elem_addr   (elem_addr),
  .elem_index  (elem_index),
  .elem_last   (elem_last),
  .busy        (busy),
  .done        (done)
);

// File: tb/vagu_top_tb.sv
module vagu_top_tb;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int NV = 6;

  // stimulus table: base, offset, stride, count, stall-before-accept
  localparam logic [AW-1:0] T_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFF0,
                                            32'h0000_0100, 32'h0000_0000, 32'h0000_ABC0};
  localparam logic [AW-1:0] T_OFF  [NV] = '{32'h10, 32'h0, 32'h8, 32'h40, 32'h0, 32'h4};
  localparam logic [AW-1:0] T_STEP [NV] = '{32'h1, 32'h8, 32'h4, 32'hFFFF_FFFC, 32'h0, 32'h100};
  localparam logic [LW-1:0] T_CNT  [NV] = '{16'd4, 16'd5, 16'd6, 16'd3, 16'd1, 16'd0};
  localparam bit            T_STALL[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0, addr_offset = '0, addr_step = '0;
  logic [LW-1:0] elem_count = '0;
  logic          elem_ready = 1'b0;
  logic          elem_valid, elem_last, busy, done;
  logic [AW-1:0] elem_addr;
  logic [LW-1:0] elem_index;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  vagu_top #(.ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .addr_offset(addr_offset), .addr_step(addr_step), .elem_count(elem_count),
    .elem_ready(elem_ready), .elem_valid(elem_valid), .elem_addr(elem_addr),
    .elem_index(elem_index), .elem_last(elem_last), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      summary();
    end
  end

  task automatic pulse_start(input logic [AW-1:0] b, input logic [AW-1:0] o,
                             input logic [AW-1:0] s, input logic [LW-1:0] n);
    base_addr = b; addr_offset = o; addr_step = s; elem_count = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_stream(input logic [AW-1:0] b, input logic [AW-1:0] o,
                            input logic [AW-1:0] s, input logic [LW-1:0] n,
                            input bit stall);
    logic [AW-1:0] exp_a;
    pulse_start(b, o, s, n);
    if (n == '0) begin
      chk(done == 1'b1, "R8", "done after zero count", AW'(done), 1);
      chk(elem_valid == 1'b0, "R8", "valid on zero count", AW'(elem_valid), 0);
      chk(busy == 1'b0, "R8", "busy on zero count", AW'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done width", AW'(done), 0);
      return;
    end
    exp_a = b + o;  // R2, R9: wraps at AW bits
    for (int i = 0; i < int'(n); i++) begin
      if (stall) begin
        elem_ready = 1'b0;
        @(negedge clk);
        chk(elem_valid == 1'b1, "R6", "valid held", AW'(elem_valid), 1);
        chk(elem_addr == exp_a, "R6", "addr held", elem_addr, exp_a);
        chk(elem_index == LW'(i), "R6", "index held", AW'(elem_index), AW'(i));
      end
      chk(elem_valid == 1'b1, "R2", "valid", AW'(elem_valid), 1);
      chk(busy == 1'b1, "R11", "busy in stream", AW'(busy), 1);
      chk(elem_addr == exp_a, "R3", "element addr", elem_addr, exp_a);
      chk(elem_index == LW'(i), "R5", "element index", AW'(elem_index), AW'(i));
      chk(elem_last == (i == int'(n) - 1), "R5", "last flag", AW'(elem_last),
          AW'(i == int'(n) - 1));
      elem_ready = 1'b1;
      @(negedge clk);
      elem_ready = 1'b0;
      exp_a = exp_a + s;  // R4
    end
    chk(elem_valid == 1'b0, "R7", "valid after last", AW'(elem_valid), 0);
    chk(busy == 1'b0, "R11", "busy after last", AW'(busy), 0);
    chk(done == 1'b1, "R7", "done after last", AW'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", AW'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(elem_valid == 1'b0, "R1", "valid in reset", AW'(elem_valid), 0);
    chk(busy == 1'b0, "R1", "busy in reset", AW'(busy), 0);
    chk(done == 1'b0, "R1", "done in reset", AW'(done), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: contiguous (R4), stalled stride (R6), wrap (R9),
    // negative stride (R9), single element (R5), zero count (R8)
    for (int v = 0; v < NV; v++)
      run_stream(T_BASE[v], T_OFF[v], T_STEP[v], T_CNT[v], T_STALL[v]);

    // R10: start while busy is discarded
    pulse_start(32'h0000_4000, 32'h0, 32'h10, 16'd3);
    base_addr = 32'h9999_0000; addr_step = 32'h1; elem_count = 16'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(elem_addr == 32'h0000_4000, "R10", "addr after ignored start", elem_addr, 32'h4000);
    for (int i = 0; i < 3; i++) begin
      chk(elem_addr == 32'h4000 + 32'(i) * 32'h10, "R10", "kept stride", elem_addr,
          32'h4000 + 32'(i) * 32'h10);
      chk(elem_last == (i == 2), "R10", "kept count", AW'(elem_last), AW'(i == 2));
      elem_ready = 1'b1;
      @(negedge clk);
      elem_ready = 1'b0;
    end
    chk(busy == 1'b0, "R10", "stream ended at original count", AW'(busy), 0);
    @(negedge clk);

    // R4: zero stride repeats one address
    run_stream(32'h0000_0800, 32'h4, 32'h0, 16'd3, 1'b0);

    // R1: reset in mid-stream clears the outputs
    pulse_start(32'h0000_5000, 32'h0, 32'h4, 16'd5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(elem_valid == 1'b0, "R1", "valid after mid reset", AW'(elem_valid), 0);
    chk(busy == 1'b0, "R1", "busy after mid reset", AW'(busy), 0);

    summary();
  end
endmodule